// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Compare and Rollover Flags

This block is a word-addressed timer peripheral. A counter advances by one on every prescaled tick taken from one of two clock-enable inputs: a fast one and a slow one. A single compare register acts in one of two ways, chosen by a mode bit in the control word:

- **Restart mode:** a compare hit sends the counter back to zero.
- **Freerun mode:** the counter runs on through the compare value and wraps only after all ones.

Two sticky status flags record compare hits and rollovers. Each flag has an enable bit in the interrupt-enable register. Together they drive one level interrupt, which is gated by the enable bit in the control word.

Software programs the control word, the prescaler, the interrupt-enable mask and the compare value over a simple single-cycle write port. It reads any of these, the status and the live count through a combinational read port. A soft-reset bit in the control word returns the block to a known idle state. It leaves the rest of the configuration alone. Control bits for low-power gating are stored and read back but have no effect.

Top module: `gp_uptimer`

## Requirements
- R1: After hard reset the control word, prescaler, status, interrupt mask and count read 0. The compare register reads all ones (counter width), and irq is low.
- R2: The counter holds its value while control bit 0 (enable) is 0. While enabled, it rises by exactly one per prescaled tick.
- R3: With prescaler value P (12 bits, word offset 1), the counter advances once every P+1 ticks of the selected source.
- R4: Control bits 8:6 select the source. Code 001 or 010 selects main_tick_en, code 100 selects slow_tick_en, and every other code selects no source, so the counter does not advance.
- R5: In restart mode (control bit 9 = 0), a tick taken while the count equals the compare value sends the count to 0 and sets status bit 0.
- R6: In freerun mode (control bit 9 = 1), a tick at the compare value sets status bit 0 and the count continues. A tick at all ones wraps to 0 and sets status bit 5. A compare value of all ones sets both bits on the same tick.
- R7: Writing the control word so that enable goes from 0 to 1 with bit 1 set clears the count. With bit 1 clear, counting resumes from the held value.
- R8: A write to the compare register (offset 4) in restart mode clears the count. In freerun mode the count is left unchanged.
- R9: Status (offset 2) is write-one-to-clear on bits 0 and 5. A flag set by hardware in the same cycle as a clear stays set.
- R10: irq is high exactly when enable is 1 and either (status bit 0 and mask bit 0) or (status bit 5 and mask bit 5) is set. The mask register keeps 6 bits.
- R11: Writing control with bit 15 set performs a soft reset. It clears control bits 0, 2, 3 and 4, keeps the other control bits, and clears the count, the status and the mask. Control bits 15:10 always read 0.
- R12: The read map is: 0 control, 1 prescaler, 2 status, 3 mask, 4 compare, 9 count. Every other offset reads 0 and ignores writes. Writes to offset 9 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hard reset, released synchronously inside the block |
| main_tick_en | input | 1 | Clock enable of the main tick source |
| slow_tick_en | input | 1 | Clock enable of the slow tick source |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| addr | input | AW (4) | Word offset of the register accessed |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data of the register at addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A wrong prescale phase shows up within P+1 source ticks as a count that moves one cycle early or late on the count read-back. The bench compares that read-back against its reference model on every clock. A wrong mode decision shows up at the first compare hit: either as a count that fails to return to zero or as a status flag missing from the status read. A wrong status or mask bit reaches irq in the cycle after the tick that should have set it. Soft-reset and enable-restart errors show up in the read-back on the clock after the control write.

// File: rtl/gp_uptimer_pkg.sv
`timescale 1ns/1ps
package gp_uptimer_pkg;
  // Word offsets of the register map
  localparam int OFS_CTRL = 0;
  localparam int OFS_PRE  = 1;
  localparam int OFS_STAT = 2;
  localparam int OFS_IEN  = 3;
  localparam int OFS_CMP  = 4;
  localparam int OFS_CNT  = 9;

  // Control word bit positions
  localparam int B_EN     = 0;
  localparam int B_ENMOD  = 1;
  localparam int SRC_LSB  = 6;
  localparam int B_FRR    = 9;
  localparam int B_SWR    = 15;

  // Status / mask bit positions
  localparam int ST_CMP   = 0;
  localparam int ST_ROV   = 5;

  // Bits kept on a control write (15:10 dropped)
  localparam logic [31:0] CTRL_KEEP = 32'hFFFF_03FF;
  // Bits cleared by a soft reset: enable and three low-power enables
  localparam logic [31:0] SWR_CLR   = 32'h0000_001D;

  typedef enum logic [2:0] {
    SRC_OFF     = 3'b000,
    SRC_MAIN    = 3'b001,
    SRC_MAIN_HF = 3'b010,
    SRC_SLOW    = 3'b100
  } src_e;
endpackage

// File: rtl/gp_uptimer_regs.sv
`timescale 1ns/1ps
module gp_uptimer_regs
  import gp_uptimer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int PW = 12,
  parameter int IW = 6,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [PW-1:0] pre_q,
  output logic [IW-1:0] ien_q,
  output logic [CW-1:0] cmp_q,
  output logic          swr_pulse,
  output logic          en_restart,
  output logic          cmp_restart,
  output logic [1:0]    stat_w1c
);
  localparam logic [DW-1:0] KEEP_MASK = DW'(CTRL_KEEP);
  localparam logic [DW-1:0] SWR_MASK  = DW'(SWR_CLR);

  logic wr_ctrl, wr_pre, wr_stat, wr_ien, wr_cmp;
  logic [DW-1:0] ctrl_d;
  logic [PW-1:0] pre_d;
  logic [IW-1:0] ien_d;
  logic [CW-1:0] cmp_d;

  assign wr_ctrl = wr_en && (addr == AW'(OFS_CTRL));
  assign wr_pre  = wr_en && (addr == AW'(OFS_PRE));
  assign wr_stat = wr_en && (addr == AW'(OFS_STAT));
  assign wr_ien  = wr_en && (addr == AW'(OFS_IEN));
  assign wr_cmp  = wr_en && (addr == AW'(OFS_CMP));

  assign swr_pulse   = wr_ctrl && wdata[B_SWR];
  assign en_restart  = wr_ctrl && !wdata[B_SWR] && !ctrl_q[B_EN]
                       && wdata[B_EN] && wdata[B_ENMOD];
  assign cmp_restart = wr_cmp && !ctrl_q[B_FRR];
  assign stat_w1c    = wr_stat ? {wdata[ST_ROV], wdata[ST_CMP]} : 2'b00;

  always_comb begin
    ctrl_d = ctrl_q;
    pre_d  = pre_q;
    ien_d  = ien_q;
    cmp_d  = cmp_q;
    if (swr_pulse) begin
      ctrl_d = ctrl_q & ~SWR_MASK;
      ien_d  = '0;
    end else if (wr_ctrl) begin
      ctrl_d = wdata & KEEP_MASK;
    end
    if (wr_pre) pre_d = wdata[PW-1:0];
    if (wr_ien) ien_d = wdata[IW-1:0];
    if (wr_cmp) cmp_d = wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      pre_q  <= pre_d;
      ien_q  <= ien_d;
      cmp_q  <= cmp_d;
    end
  end
endmodule

// File: rtl/gp_uptimer_prescale.sv
`timescale 1ns/1ps
module gp_uptimer_prescale
  import gp_uptimer_pkg::*;
#(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    src_sel,
  input  logic          main_tick,
  input  logic          slow_tick,
  input  logic [PW-1:0] pre,
  input  logic          clr,
  output logic          cnt_tick
);
  logic          src_tick;
  logic          wrap;
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    case (src_sel)
      SRC_MAIN, SRC_MAIN_HF: src_tick = main_tick;
      SRC_SLOW:              src_tick = slow_tick;
      default:               src_tick = 1'b0;
    endcase
  end

  assign wrap     = (pc_q >= pre);
  assign cnt_tick = en && src_tick && wrap;

  always_comb begin
    pc_d = pc_q;
    if (!en || clr)    pc_d = '0;
    else if (src_tick) pc_d = wrap ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/gp_uptimer_core.sv
`timescale 1ns/1ps
module gp_uptimer_core #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          frr,
  input  logic [CW-1:0] cmp,
  input  logic          clr_cnt,
  input  logic          swr,
  input  logic [1:0]    stat_w1c,
  output logic [CW-1:0] cnt_q,
  output logic [1:0]    stat_q
);
  logic          hit, roll;
  logic [CW-1:0] cnt_d;
  logic [1:0]    stat_d;

  assign hit  = cnt_tick && (cnt_q == cmp);
  assign roll = cnt_tick && (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_cnt)       cnt_d = '0;
    else if (cnt_tick) cnt_d = (hit && !frr) ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    if (swr) stat_d = 2'b00;
    else     stat_d = (stat_q & ~stat_w1c) | {roll, hit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/gp_uptimer.sv
`timescale 1ns/1ps
module gp_uptimer
  import gp_uptimer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int CW = 32,
  parameter int PW = 12,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_tick_en,
  input  logic          slow_tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic          rst_meta, rst_sync_n;
  logic [DW-1:0] ctrl_q;
  logic [PW-1:0] pre_q;
  logic [IW-1:0] ien_q;
  logic [CW-1:0] cmp_q, cnt_q;
  logic [1:0]    stat_q, stat_w1c;
  logic          swr_pulse, en_restart, cmp_restart, cnt_tick;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  gp_uptimer_regs #(.DW(DW), .AW(AW), .PW(PW), .IW(IW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_q(ctrl_q), .pre_q(pre_q), .ien_q(ien_q), .cmp_q(cmp_q),
    .swr_pulse(swr_pulse), .en_restart(en_restart),
    .cmp_restart(cmp_restart), .stat_w1c(stat_w1c)
  );

  gp_uptimer_prescale #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .en(ctrl_q[B_EN]),
    .src_sel(ctrl_q[SRC_LSB+2:SRC_LSB]), .main_tick(main_tick_en),
    .slow_tick(slow_tick_en), .pre(pre_q), .clr(swr_pulse),
    .cnt_tick(cnt_tick)
  );

  gp_uptimer_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .cnt_tick(cnt_tick), .frr(ctrl_q[B_FRR]),
    .cmp(cmp_q), .clr_cnt(swr_pulse || en_restart || cmp_restart),
    .swr(swr_pulse), .stat_w1c(stat_w1c), .cnt_q(cnt_q), .stat_q(stat_q)
  );

  assign irq = ctrl_q[B_EN] &&
               ((stat_q[0] && ien_q[ST_CMP]) || (stat_q[1] && ien_q[ST_ROV]));

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(OFS_CTRL): rdata = ctrl_q;
      AW'(OFS_PRE):  rdata = DW'(pre_q);
      AW'(OFS_STAT): begin
        rdata[ST_CMP] = stat_q[0];
        rdata[ST_ROV] = stat_q[1];
      end
      AW'(OFS_IEN):  rdata = DW'(ien_q);
      AW'(OFS_CMP):  rdata = DW'(cmp_q);
      AW'(OFS_CNT):  rdata = DW'(cnt_q);
      default:       rdata = '0;
    endcase
  end
endmodule

// File: rtl/gp_uptimer_sva.sv
`timescale 1ns/1ps
module gp_uptimer_sva #(
  parameter int CW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          swr_bit,
  input logic          en,
  input logic          frr,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp,
  input logic [1:0]    stat,
  input logic          cnt_tick,
  input logic          irq
);
  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && frr && !wr_en) |=> (cnt == $past(cnt) + 1'b1));

  assert_restart_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !frr && (cnt == cmp) && !wr_en) |=> ((cnt == '0) && stat[0]));

  assert_rollover_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && (&cnt) && !wr_en) |=> stat[1]);

  assert_cmp_write_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == AW'(4)) && !frr) |=> (cnt == '0));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == AW'(0)) && swr_bit) |=>
      ((cnt == '0) && (stat == 2'b00) && !en && !irq));
endmodule

bind gp_uptimer gp_uptimer_sva #(.CW(CW), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr),
  .swr_bit(wdata[gp_uptimer_pkg::B_SWR]), .en(ctrl_q[gp_uptimer_pkg::B_EN]),
  .frr(ctrl_q[gp_uptimer_pkg::B_FRR]), .cnt(cnt_q), .cmp(cmp_q),
  .stat(stat_q), .cnt_tick(cnt_tick), .irq(irq)
);

// File: tb/gp_uptimer_bench.sv
`timescale 1ns/1ps
module gp_uptimer_bench;
  localparam int CW = 8;
  localparam logic [CW-1:0] CMAX = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        main_tick_en = 1'b0, slow_tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  gp_uptimer #(.CW(CW)) u_gp_uptimer (
    .clk(clk), .rst_n(rst_n), .main_tick_en(main_tick_en),
    .slow_tick_en(slow_tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    started = 0, done = 0, main_on = 0, slow_on = 0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [31:0]   m_ctrl;
  logic [11:0]   m_pr, m_pc;
  logic [5:0]    m_ir;
  logic [CW-1:0] m_cnt, m_cmp;
  logic          m_f0, m_f5;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return {20'd0, m_pr};
      4'd2: return {26'd0, m_f5, 4'd0, m_f0};
      4'd3: return {26'd0, m_ir};
      4'd4: return 32'(m_cmp);
      4'd9: return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    return m_ctrl[0] && ((m_f0 && m_ir[0]) || (m_f5 && m_ir[5]));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pr = 0; m_pc = 0; m_ir = 0;
      m_cnt = 0; m_cmp = CMAX; m_f0 = 0; m_f5 = 0;
    end else begin
      logic src, tk, hit, rov;
      case (m_ctrl[8:6])
        3'd1, 3'd2: src = main_tick_en;
        3'd4:       src = slow_tick_en;
        default:    src = 1'b0;
      endcase
      tk = 1'b0;
      if (!m_ctrl[0]) m_pc = 0;
      else if (src) begin
        if (m_pc >= m_pr) begin m_pc = 0; tk = 1'b1; end
        else m_pc = m_pc + 1;
      end
      hit = tk && (m_cnt == m_cmp);
      rov = tk && (m_cnt == CMAX);
      if (wr_en && addr == 4'd2) begin
        if (wdata[0]) m_f0 = 1'b0;
        if (wdata[5]) m_f5 = 1'b0;
      end
      m_f0 = m_f0 | hit;
      m_f5 = m_f5 | rov;
      if (tk) m_cnt = (hit && !m_ctrl[9]) ? '0 : m_cnt + 1'b1;
      if (wr_en) begin
        case (addr)
          4'd0: if (wdata[15]) begin
                  m_ctrl = m_ctrl & ~32'h1D; m_cnt = 0; m_f0 = 0; m_f5 = 0;
                  m_ir = 0; m_pc = 0;
                end else begin
                  if (!m_ctrl[0] && wdata[0] && wdata[1]) m_cnt = 0;
                  m_ctrl = wdata & 32'hFFFF_03FF;
                end
          4'd1: m_pr = wdata[11:0];
          4'd3: m_ir = wdata[5:0];
          4'd4: begin
                  if (!m_ctrl[9]) m_cnt = 0;
                  m_cmp = wdata[CW-1:0];
                end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #1;
    if (started && !done) begin
      chk(cur_req, rdata, m_read(addr), "rdata");
      chk(cur_req, {31'd0, irq}, {31'd0, m_irq()}, "irq");
    end
  end

  task automatic drive(input logic we, input int a, input logic [31:0] d);
    @(negedge clk);
    cyc++;
    wr_en = we; addr = 4'(a); wdata = d;
    main_tick_en = main_on;
    slow_tick_en = slow_on && (cyc % 3 == 0);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    drive(1'b1, a, d);
  endtask

  task automatic idle(input int n, input int a);
    for (int i = 0; i < n; i++) drive(1'b0, a, 32'd0);
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    drive(1'b0, a, 32'd0);
    #1 v = rdata;
  endtask

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4, 0);
    started = 1;

    // R1: reset values
    cur_req = "R1";
    rd(0, v); chk("R1", v, 32'h0, "ctrl after reset");
    rd(4, v); chk("R1", v, 32'h0000_00FF, "compare after reset");
    rd(9, v); chk("R1", v, 32'h0, "count after reset");
    rd(2, v); chk("R1", v, 32'h0, "status after reset");
    chk("R1", {31'd0, irq}, 32'h0, "irq after reset");

    // R12: unmapped and read-only offsets
    cur_req = "R12";
    wr(9, 32'h55); wr(7, 32'hFFFF_FFFF);
    rd(9, v); chk("R12", v, 32'h0, "count after write to offset 9");
    rd(7, v); chk("R12", v, 32'h0, "unmapped offset 7");
    rd(12, v); chk("R12", v, 32'h0, "unmapped offset 12");

    // R10 mask width, R11 soft reset and dropped control bits
    cur_req = "R11";
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); chk("R10", v, 32'h3F, "mask keeps 6 bits");
    wr(0, 32'hFFFF_7FFF);
    rd(0, v); chk("R11", v, 32'hFFFF_03FF, "control bits 15:10 read zero");
    wr(0, 32'h0000_8000);
    rd(0, v); chk("R11", v, 32'hFFFF_03E2, "soft reset keeps unrelated bits");
    rd(3, v); chk("R11", v, 32'h0, "soft reset clears mask");
    wr(0, 32'h0);

    // R4: source selection
    cur_req = "R4";
    main_on = 1; slow_on = 1;
    wr(1, 0);
    wr(0, 32'h0C1); idle(10, 9);
    rd(9, v); chk("R4", v, 32'h0, "undefined source code does not count");
    wr(0, 32'h0);
    wr(0, 32'h101); idle(12, 9);
    wr(0, 32'h081); idle(8, 9);
    wr(0, 32'h001); idle(5, 9);

    // R3: prescaler
    cur_req = "R3";
    wr(0, 32'h0); wr(1, 3); wr(0, 32'h043); idle(30, 9);
    wr(1, 0);

    // R5, R9, R10: restart mode compare
    cur_req = "R5";
    wr(0, 32'h0); wr(4, 5); wr(3, 1); wr(0, 32'h043); idle(20, 2);
    rd(2, v); chk("R5", v, 32'h1, "compare flag in restart mode");
    cur_req = "R9";
    wr(2, 32'h1); idle(20, 2);
    cur_req = "R10";
    wr(3, 0); idle(4, 9);

    // R8: compare write clears only in restart mode
    cur_req = "R8";
    wr(4, 9); idle(12, 9);
    wr(0, 32'h241); wr(4, 3); idle(10, 9);

    // R6, R10: freerun rollover and compare at all ones
    cur_req = "R6";
    wr(3, 32'h21); wr(2, 32'h21); idle(300, 9);
    wr(4, 32'hFF); idle(300, 2);

    // R7: enable mode
    cur_req = "R7";
    wr(0, 32'h240); idle(5, 9);
    wr(0, 32'h241); idle(5, 9);
    wr(0, 32'h240); wr(0, 32'h243); idle(5, 9);

    // R11: soft reset while running
    cur_req = "R11";
    wr(0, 32'h8243); idle(5, 9);
    rd(0, v); chk("R11", v, 32'h242, "control after running soft reset");
    rd(9, v); chk("R11", v, 32'h0, "count held at zero after soft reset");

    idle(3, 0);
    report();
  end
endmodule